// File: doc/BRIEF.md
# Master / Split-Return Port Arbiter

This block decides which of two sources may drive a single shared bus port. The first source is the master's stream of new outgoing accesses. The second is the target's stream of split completions that return data for earlier requests. Each source has its own request/grant pair. A configuration input carries a 2-bit priority per source and a mode bit. In fixed mode the numerically lower priority value wins. In rotating mode the source that won most recently yields to the other. The port reports a busy level, and a grant is held while the port is busy.

The configuration is registered inside the block, so changes reach the arbitration one cycle after they are presented. Grants are registered outputs and are always one-hot or idle. The arbiter only chooses between the sources. It does not carry transactions or drive bus timing.

Top module: `split_arb`

## Requirements
- R1: In fixed mode (mode bit 0), when both sources request, the source whose registered 2-bit priority value is numerically lower is granted; 0 is the most urgent value and 3 the least.
- R2: In fixed mode, when both sources request with equal priority values, the split-return source is granted.
- R3: In rotating mode (mode bit 1), when both sources request, the source that did not receive the most recent grant is granted, regardless of the priority values. The most-recent record is updated on every new grant in either mode.
- R4: A grant is registered: when no grant is active, or the port is not busy, the decision made from the requests at a clock edge appears on the grant outputs immediately after that edge.
- R5: While a grant is active and port busy is high, that grant stays unchanged whatever the requests or configuration do; arbitration resumes at the first edge at which busy is low.
- R6: At most one grant is high at any time. A grant only rises for a source that was requesting at that edge. With no request and busy low, both grants are low after the next edge.
- R7: Synchronous active-low reset clears both grants, clears the registered priorities and mode to 0, and sets the most-recent record to the master, so the split return wins the first rotating tie.
- R8: The priority and mode inputs are sampled into registers every cycle; an arbitration at an edge uses the values captured at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_req | input | 1 | Master requests the port for a new access |
| spl_req | input | 1 | Target requests the port for a split return |
| mst_prio | input | PRIO_W | Master priority, 0 most urgent |
| spl_prio | input | PRIO_W | Split-return priority, 0 most urgent |
| rot_mode | input | 1 | 0 fixed priority, 1 rotating |
| port_busy | input | 1 | Port is still occupied by the current owner |
| mst_gnt | output | 1 | Master owns the port |
| spl_gnt | output | 1 | Split return owns the port |

## Verification
The bench builds the arbiter with the default 2-bit priority width, which lets every priority value from 0 to 3 be driven, including both extremes against each other and equal values for the tie rule. With this width the vector table can cover both modes and all request combinations, together with the one-cycle configuration lag right after reset. Directed steps then hold a grant under busy while the requests and priorities move against it.

// File: rtl/split_arb_pkg.sv
// Shared definitions for the two-source port arbiter.
// Assumes exactly two sources; index 0 is the master, index 1 the split return.
package split_arb_pkg;
    localparam int PRIO_W_DEF = 2;
    localparam int NSRC       = 2;
    localparam int IDX_MST    = 0;
    localparam int IDX_SPL    = 1;

    typedef enum logic {
        SRC_MST = 1'b0,
        SRC_SPL = 1'b1
    } src_e;
endpackage

// File: rtl/split_arb_cfg.sv
// Configuration capture: registers the per-source priorities and the mode bit.
// Assumes the configuration may change at any cycle; the new value is used one cycle later.
module split_arb_cfg #(
    parameter int PW = split_arb_pkg::PRIO_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] mst_prio_i,
    input  logic [PW-1:0] spl_prio_i,
    input  logic          rot_i,
    output logic [PW-1:0] mst_prio_q,
    output logic [PW-1:0] spl_prio_q,
    output logic          rot_q
);
    // Capture configuration each cycle, cleared to zero in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_prio_q <= '0;
            spl_prio_q <= '0;
            rot_q      <= 1'b0;
        end else begin
            mst_prio_q <= mst_prio_i;
            spl_prio_q <= spl_prio_i;
            rot_q      <= rot_i;
        end
    end
endmodule

// File: rtl/split_arb_pick.sv
// Combinational winner selection between the two sources.
// Assumes req bit 0 is the master and bit 1 the split return; output is one-hot or zero.
module split_arb_pick #(
    parameter int PW = split_arb_pkg::PRIO_W_DEF
) (
    input  logic [split_arb_pkg::NSRC-1:0] req_i,
    input  logic [PW-1:0]                  mst_prio_i,
    input  logic [PW-1:0]                  spl_prio_i,
    input  logic                           rot_i,
    input  split_arb_pkg::src_e            last_i,
    output logic [split_arb_pkg::NSRC-1:0] win_o
);
    import split_arb_pkg::*;

    logic spl_beats_fixed;
    logic spl_beats_rot;
    logic spl_beats;

    // Fixed order: lower value wins, ties go to the split return.
    always_comb spl_beats_fixed = (spl_prio_i <= mst_prio_i);

    // Rotating order: the source not granted last goes first.
    always_comb spl_beats_rot = (last_i == SRC_MST);

    // Choose the comparison the mode asks for.
    always_comb spl_beats = rot_i ? spl_beats_rot : spl_beats_fixed;

    // Build the one-hot winner from the requests.
    always_comb begin
        win_o = '0;
        if (req_i[IDX_SPL] && req_i[IDX_MST]) begin
            win_o[IDX_SPL] = spl_beats;
            win_o[IDX_MST] = !spl_beats;
        end else begin
            win_o = req_i;
        end
    end
endmodule

// File: rtl/split_arb_own.sv
// Grant register: holds the current owner while the port is busy and
// records which source was granted most recently.
// Assumes win_i is one-hot or zero.
module split_arb_own (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           busy_i,
    input  logic [split_arb_pkg::NSRC-1:0] win_i,
    output logic [split_arb_pkg::NSRC-1:0] gnt_o,
    output split_arb_pkg::src_e            last_o
);
    import split_arb_pkg::*;

    logic rearb;

    // Re-arbitrate when nobody owns the port or the owner has released it.
    always_comb rearb = (gnt_o == '0) || !busy_i;

    // Update the grant and the most-recent record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_o  <= '0;
            last_o <= SRC_MST;
        end else if (rearb) begin
            gnt_o <= win_i;
            if (win_i[IDX_SPL])
                last_o <= SRC_SPL;
            else if (win_i[IDX_MST])
                last_o <= SRC_MST;
        end
    end
endmodule

// File: rtl/split_arb.sv
// Top level: arbitrates one bus port between master accesses and split returns.
// Assumes port_busy refers to the current grant holder.
module split_arb #(
    parameter int PRIO_W = split_arb_pkg::PRIO_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_req,
    input  logic              spl_req,
    input  logic [PRIO_W-1:0] mst_prio,
    input  logic [PRIO_W-1:0] spl_prio,
    input  logic              rot_mode,
    input  logic              port_busy,
    output logic              mst_gnt,
    output logic              spl_gnt
);
    import split_arb_pkg::*;

    logic [PRIO_W-1:0] mst_prio_q;
    logic [PRIO_W-1:0] spl_prio_q;
    logic              rot_q;
    logic [NSRC-1:0]   req_v;
    logic [NSRC-1:0]   win_v;
    logic [NSRC-1:0]   gnt_v;
    src_e              last_src;

    // Gather the requests into a source-indexed vector.
    always_comb begin
        req_v          = '0;
        req_v[IDX_MST] = mst_req;
        req_v[IDX_SPL] = spl_req;
    end

    split_arb_cfg #(.PW(PRIO_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mst_prio_i (mst_prio),
        .spl_prio_i (spl_prio),
        .rot_i      (rot_mode),
        .mst_prio_q (mst_prio_q),
        .spl_prio_q (spl_prio_q),
        .rot_q      (rot_q)
    );

    split_arb_pick #(.PW(PRIO_W)) u_pick (
        .req_i      (req_v),
        .mst_prio_i (mst_prio_q),
        .spl_prio_i (spl_prio_q),
        .rot_i      (rot_q),
        .last_i     (last_src),
        .win_o      (win_v)
    );

    split_arb_own u_own (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (port_busy),
        .win_i  (win_v),
        .gnt_o  (gnt_v),
        .last_o (last_src)
    );

    assign mst_gnt = gnt_v[IDX_MST];
    assign spl_gnt = gnt_v[IDX_SPL];
endmodule

// File: rtl/split_arb_chk.sv
// Property checker for the port arbiter, attached by bind.
module split_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic mst_req,
    input logic spl_req,
    input logic port_busy,
    input logic mst_gnt,
    input logic spl_gnt
);
    logic seen_clk;

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) seen_clk <= 1'b1;

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mst_gnt, spl_gnt}));

    p_mst_rise_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_gnt) |-> $past(mst_req));

    p_spl_rise_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spl_gnt) |-> $past(spl_req));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_busy && !mst_req && !spl_req) |=> (!mst_gnt && !spl_gnt));

    p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mst_gnt || spl_gnt) && port_busy) |=> $stable({mst_gnt, spl_gnt}));

    p_grant_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mst_gnt && !spl_gnt && (mst_req || spl_req)) |=> (mst_gnt || spl_gnt));

    // R7: a reset edge leaves both grants low.
    always @(posedge clk) begin
        if (seen_clk && rst_n && !$past(rst_n))
            p_reset_clear_r7: assert (!mst_gnt && !spl_gnt);
    end
endmodule

bind split_arb split_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_req   (mst_req),
    .spl_req   (spl_req),
    .port_busy (port_busy),
    .mst_gnt   (mst_gnt),
    .spl_gnt   (spl_gnt)
);

// File: tb/split_arb_bench.sv
// Bench for the port arbiter: vector table walk, then directed reset and busy cases.
module split_arb_bench;
    localparam int PW   = 2;
    localparam int NVEC = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mst_req, spl_req, rot_mode, port_busy;
    logic [PW-1:0] mst_prio, spl_prio;
    logic          mst_gnt, spl_gnt;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    split_arb #(.PRIO_W(PW)) u_split_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .mst_req   (mst_req),
        .spl_req   (spl_req),
        .mst_prio  (mst_prio),
        .spl_prio  (spl_prio),
        .rot_mode  (rot_mode),
        .port_busy (port_busy),
        .mst_gnt   (mst_gnt),
        .spl_gnt   (spl_gnt)
    );

    // Fields: [8] mode, [7:6] master prio, [5:4] split prio,
    // [3] master req, [2] split req, [1] expected master grant, [0] expected split grant.
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_00_00_11_01,  // R2 tie, split wins
        9'b0_00_01_11_10,  // R1 master lower
        9'b0_11_10_11_01,  // R1 split lower
        9'b0_01_01_11_01,  // R2 tie at 1
        9'b0_00_11_01_01,  // R6 lone split request
        9'b0_11_00_10_10,  // R6 lone master request
        9'b0_00_00_00_00,  // R6 no request
        9'b1_11_00_11_01,  // R3 last was master
        9'b1_00_00_11_10,  // R3 alternates
        9'b1_00_00_11_01,  // R3 alternates
        9'b1_00_00_01_01,  // R3 lone split
        9'b1_00_00_11_10,  // R3 after split
        9'b1_00_00_00_00,  // R6 no request
        9'b0_10_10_11_01,  // R2 tie at 2
        9'b1_00_00_11_10   // R3 record kept across fixed grant
    };

    task automatic chk(input string rq, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: grants {mst,spl} = %b, expected %b", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d, expected under 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        mst_req   = 1'b1;
        spl_req   = 1'b1;
        mst_prio  = 2'd0;
        spl_prio  = 2'd3;
        rot_mode  = 1'b0;
        port_busy = 1'b0;
        @(negedge clk);
        step();
        step();
        chk("R7 grants clear in reset", {mst_gnt, spl_gnt}, 2'b00);

        // R7/R8: first decision uses the zero reset configuration (tie -> split).
        rst_n = 1'b1;
        step();
        chk("R7 R8 reset config used first", {mst_gnt, spl_gnt}, 2'b01);
        step();
        chk("R8 R1 captured config applies", {mst_gnt, spl_gnt}, 2'b10);

        // Vector walk: configure with no request, then request and check.
        for (int i = 0; i < NVEC; i++) begin
            mst_req  = 1'b0;
            spl_req  = 1'b0;
            rot_mode = VEC[i][8];
            mst_prio = VEC[i][7:6];
            spl_prio = VEC[i][5:4];
            step();
            mst_req = VEC[i][3];
            spl_req = VEC[i][2];
            step();
            chk($sformatf("R1 R2 R3 R4 vector %0d", i), {mst_gnt, spl_gnt}, VEC[i][1:0]);
        end

        // R5: grant held under busy against a more urgent split return.
        mst_req  = 1'b0;
        spl_req  = 1'b0;
        rot_mode = 1'b0;
        mst_prio = 2'd0;
        spl_prio = 2'd1;
        step();
        mst_req = 1'b1;
        spl_req = 1'b1;
        step();
        chk("R1 master granted before busy", {mst_gnt, spl_gnt}, 2'b10);
        port_busy = 1'b1;
        mst_req   = 1'b0;
        spl_req   = 1'b1;
        mst_prio  = 2'd3;
        spl_prio  = 2'd0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R5 grant held while busy", {mst_gnt, spl_gnt}, 2'b10);
        end
        port_busy = 1'b0;
        step();
        chk("R5 re-arbitrated after busy low", {mst_gnt, spl_gnt}, 2'b01);
        spl_req = 1'b0;
        step();
        chk("R6 no request drops grant", {mst_gnt, spl_gnt}, 2'b00);

        // R6: busy with no owner and no request grants nothing.
        port_busy = 1'b1;
        step();
        chk("R6 idle busy grants nothing", {mst_gnt, spl_gnt}, 2'b00);
        port_busy = 1'b0;

        // R7: reset mid-operation clears the grant and rotation record.
        mst_req  = 1'b1;
        spl_req  = 1'b1;
        rot_mode = 1'b1;
        step();
        rst_n = 1'b0;
        step();
        chk("R7 reset clears grant", {mst_gnt, spl_gnt}, 2'b00);
        rst_n = 1'b1;
        step();
        chk("R7 reset config fixed tie", {mst_gnt, spl_gnt}, 2'b01);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule